// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block divides a fast RF clock by a programmable ratio N using the pulse-swallow method. A modelled dual-modulus prescaler divides by 9 or by 8. A 3-bit swallow count A and a 12-bit main count M watch the prescaler's cycles. For A of the main cycles the prescaler runs at 9. For the remaining M − A cycles it runs at 8. Each full output cycle therefore lasts N = 8M + A RF clocks. The divided output `fpd` is a single-clock pulse. It feeds a phase comparator that lies outside this block.

A 15-bit ratio word is captured by a load strobe into a pending register. The word's low 3 bits are A and its upper 12 bits are M. The counters read the pending value only when an output cycle ends, so a ratio change never shortens or stretches a cycle in progress. A word that cannot be built from the prescaler is replaced by the smallest legal ratio and raises a flag. Such a word is one below 56, or one whose A exceeds M. In one test setting, a half-rate copy of the divided pulse train replaces the general-purpose data bit on output port 0.

The controller is a three-state machine:
- `ST_LOAD` is the first cycle after reset. It loads both counters from the pending ratio and moves to `ST_SWALLOW` when A is non-zero, otherwise to `ST_MAIN`.
- `ST_SWALLOW` runs the prescaler at 9. It moves to `ST_MAIN` when the last swallow cycle ends.
- `ST_MAIN` runs the prescaler at 8.
- When the final prescaler cycle of an output cycle ends, either running state reloads the counters and enters `ST_SWALLOW` or `ST_MAIN` according to the new A.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted and right after it, `fpd` and `mod_ctl` are 0 and `ratio_clamped` is 0. The active ratio is 56 until a word is loaded.
- R2: For a legal ratio word, with M = bits 14:3 and A = bits 2:0, consecutive `fpd` pulses are exactly 8M + A RF clock cycles apart.
- R3: Within each output cycle, `mod_ctl` is 1 (divide by 9) for exactly 9A RF cycles and 0 for the rest. It changes only at a prescaler cycle boundary.
- R4: `fpd` is high for exactly one RF cycle per output cycle.
- R5: A word below 56, or with A greater than M, is replaced by 56 (M = 7, A = 0). `ratio_clamped` reads 1 from the cycle after its load strobe.
- R6: Loading a legal word clears `ratio_clamped` in the cycle after the strobe. Without a strobe, the flag holds.
- R7: A word loaded in the middle of an output cycle leaves that cycle's length unchanged. The word takes effect from the next output cycle.
- R8: When `test_sel` = 2'b01 and not both `refout_en` and `refout_sel` are 1, `port0_out` toggles at every `fpd` pulse, giving Fpd/2.
- R9: In every other combination of `test_sel`, `refout_en` and `refout_sel`, `port0_out` equals `port0_data`.
- R10: The largest word, 32767 (M = 4095, A = 7), gives a period of 32767 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rf | input | 1 | RF input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_word | input | 15 | Ratio N; bits 14:3 = M, bits 2:0 = A |
| ratio_load | input | 1 | Strobe capturing `ratio_word` into the pending register |
| test_sel | input | 2 | Test-mode select; 2'b01 requests Fpd/2 on port 0 |
| refout_en | input | 1 | Reference-output enable bit; blocks the port-0 test route when set together with `refout_sel` |
| refout_sel | input | 1 | Reference-output select bit |
| port0_data | input | 1 | General-purpose value for port 0 |
| fpd | output | 1 | Divided output pulse, one RF cycle wide |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by 9, 0 = divide by 8 |
| ratio_clamped | output | 1 | Last loaded word was illegal and replaced by 56 |
| port0_out | output | 1 | Port 0 value: data bit or Fpd/2 |

## Verification
Every ratio from 56 to 150 is stepped through in turn. This covers all eight values of A at many values of M, including A = M, where no divide-by-8 cycles remain, so an error in either counter or in the modulus switch changes the measured period or the count of divide-by-9 cycles. Random mid-range ratios and the 32767 extreme test the upper counter bits. A word loaded part way through a cycle separates capture at the cycle boundary from capture on the strobe. Illegal words below 56, including ones with A above M, show the clamp, and a later legal word shows the flag clearing. Port 0 is driven in each test-bit combination to tell the Fpd/2 route apart from the plain data path.

// File: rtl/swal_pkg.sv
package swal_pkg;

    localparam int DEF_SW_W      = 3;
    localparam int DEF_MAIN_W    = 12;
    localparam int DEF_MIN_RATIO = 56;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_t;

endpackage

// File: rtl/swal_ratio_reg.sv
module swal_ratio_reg #(
    parameter int SW_W      = swal_pkg::DEF_SW_W,
    parameter int MAIN_W    = swal_pkg::DEF_MAIN_W,
    parameter int MIN_RATIO = swal_pkg::DEF_MIN_RATIO
) (
    input  logic                   clk_rf,
    input  logic                   rst_n,
    input  logic [SW_W+MAIN_W-1:0] ratio_word,
    input  logic                   ratio_load,
    output logic [MAIN_W-1:0]      next_m,
    output logic [SW_W-1:0]        next_a,
    output logic                   clamped
);
    localparam int RATIO_W = SW_W + MAIN_W;
    localparam logic [RATIO_W-1:0] MIN_WORD = RATIO_W'(MIN_RATIO);

    logic [RATIO_W-1:0] pend_q;
    logic [MAIN_W-1:0]  in_m;
    logic [SW_W-1:0]    in_a;
    logic               word_ok;

    always_comb begin
        in_m    = ratio_word[RATIO_W-1:SW_W];
        in_a    = ratio_word[SW_W-1:0];
        word_ok = (ratio_word >= MIN_WORD) && (MAIN_W'(in_a) <= in_m);
    end

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= MIN_WORD;
            clamped <= 1'b0;
        end else if (ratio_load) begin
            pend_q  <= word_ok ? ratio_word : MIN_WORD;
            clamped <= !word_ok;
        end
    end

    assign next_m = pend_q[RATIO_W-1:SW_W];
    assign next_a = pend_q[SW_W-1:0];

endmodule

// File: rtl/swal_prescaler.sv
module swal_prescaler #(
    parameter int SW_W = swal_pkg::DEF_SW_W
) (
    input  logic clk_rf,
    input  logic rst_n,
    input  logic running,
    input  logic modulus_hi,
    output logic pre_tc
);
    localparam int PRE_MOD = 1 << SW_W;
    localparam int PC_W    = SW_W + 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] last_cnt;

    always_comb begin
        last_cnt = modulus_hi ? PC_W'(PRE_MOD) : PC_W'(PRE_MOD - 1);
        pre_tc   = running && (pc_q == last_cnt);
    end

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!running || pre_tc) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

endmodule

// File: rtl/swal_ctrl.sv
module swal_ctrl #(
    parameter int SW_W   = swal_pkg::DEF_SW_W,
    parameter int MAIN_W = swal_pkg::DEF_MAIN_W
) (
    input  logic              clk_rf,
    input  logic              rst_n,
    input  logic              pre_tc,
    input  logic [MAIN_W-1:0] next_m,
    input  logic [SW_W-1:0]   next_a,
    output logic              running,
    output logic              modulus_hi,
    output logic              end_evt,
    output logic              fpd
);
    import swal_pkg::*;

    div_state_t        st_q, st_nx;
    logic [MAIN_W-1:0] mcnt_q, m_nx;
    logic [SW_W-1:0]   acnt_q, a_nx;
    div_state_t        reload_st;

    always_comb begin
        reload_st = (next_a != '0) ? ST_SWALLOW : ST_MAIN;
        st_nx     = st_q;
        m_nx      = mcnt_q;
        a_nx      = acnt_q;
        end_evt   = 1'b0;
        unique case (st_q)
            ST_LOAD: begin
                m_nx  = next_m;
                a_nx  = next_a;
                st_nx = reload_st;
            end
            ST_SWALLOW: begin
                if (pre_tc) begin
                    if (mcnt_q == MAIN_W'(1)) begin
                        end_evt = 1'b1;
                        m_nx    = next_m;
                        a_nx    = next_a;
                        st_nx   = reload_st;
                    end else begin
                        m_nx = mcnt_q - MAIN_W'(1);
                        a_nx = acnt_q - SW_W'(1);
                        if (acnt_q == SW_W'(1)) begin
                            st_nx = ST_MAIN;
                        end
                    end
                end
            end
            ST_MAIN: begin
                if (pre_tc) begin
                    if (mcnt_q == MAIN_W'(1)) begin
                        end_evt = 1'b1;
                        m_nx    = next_m;
                        a_nx    = next_a;
                        st_nx   = reload_st;
                    end else begin
                        m_nx = mcnt_q - MAIN_W'(1);
                    end
                end
            end
            default: begin
                st_nx = ST_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_LOAD;
            mcnt_q <= '0;
            acnt_q <= '0;
        end else begin
            st_q   <= st_nx;
            mcnt_q <= m_nx;
            acnt_q <= a_nx;
        end
    end

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) begin
            fpd <= 1'b0;
        end else begin
            fpd <= end_evt;
        end
    end

    assign running    = (st_q != ST_LOAD);
    assign modulus_hi = (st_q == ST_SWALLOW);

endmodule

// File: rtl/swal_testport.sv
module swal_testport #(
    parameter logic [1:0] HALF_CODE = 2'b01
) (
    input  logic       clk_rf,
    input  logic       rst_n,
    input  logic       end_evt,
    input  logic [1:0] test_sel,
    input  logic       refout_en,
    input  logic       refout_sel,
    input  logic       port0_data,
    output logic       port0_out
);
    logic half_q;
    logic route_half;

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (end_evt) begin
            half_q <= !half_q;
        end
    end

    always_comb begin
        route_half = (test_sel == HALF_CODE) && !(refout_en && refout_sel);
        port0_out  = route_half ? half_q : port0_data;
    end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int SW_W      = swal_pkg::DEF_SW_W,
    parameter int MAIN_W    = swal_pkg::DEF_MAIN_W,
    parameter int MIN_RATIO = swal_pkg::DEF_MIN_RATIO
) (
    input  logic                   clk_rf,
    input  logic                   rst_n,
    input  logic [SW_W+MAIN_W-1:0] ratio_word,
    input  logic                   ratio_load,
    input  logic [1:0]             test_sel,
    input  logic                   refout_en,
    input  logic                   refout_sel,
    input  logic                   port0_data,
    output logic                   fpd,
    output logic                   mod_ctl,
    output logic                   ratio_clamped,
    output logic                   port0_out
);
    logic [MAIN_W-1:0] next_m;
    logic [SW_W-1:0]   next_a;
    logic              running;
    logic              pre_tc;
    logic              end_evt;

    swal_ratio_reg #(
        .SW_W(SW_W), .MAIN_W(MAIN_W), .MIN_RATIO(MIN_RATIO)
    ) u_ratio (
        .clk_rf(clk_rf), .rst_n(rst_n),
        .ratio_word(ratio_word), .ratio_load(ratio_load),
        .next_m(next_m), .next_a(next_a), .clamped(ratio_clamped)
    );

    swal_prescaler #(.SW_W(SW_W)) u_pre (
        .clk_rf(clk_rf), .rst_n(rst_n),
        .running(running), .modulus_hi(mod_ctl), .pre_tc(pre_tc)
    );

    swal_ctrl #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_ctrl (
        .clk_rf(clk_rf), .rst_n(rst_n), .pre_tc(pre_tc),
        .next_m(next_m), .next_a(next_a),
        .running(running), .modulus_hi(mod_ctl),
        .end_evt(end_evt), .fpd(fpd)
    );

    swal_testport u_port (
        .clk_rf(clk_rf), .rst_n(rst_n), .end_evt(end_evt),
        .test_sel(test_sel), .refout_en(refout_en), .refout_sel(refout_sel),
        .port0_data(port0_data), .port0_out(port0_out)
    );

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter int SW_W      = 3,
    parameter int MAIN_W    = 12,
    parameter int MIN_RATIO = 56
) (
    input logic                   clk_rf,
    input logic                   rst_n,
    input logic [SW_W+MAIN_W-1:0] ratio_word,
    input logic                   ratio_load,
    input logic [1:0]             test_sel,
    input logic                   refout_en,
    input logic                   refout_sel,
    input logic                   fpd,
    input logic                   mod_ctl,
    input logic                   ratio_clamped,
    input logic                   port0_out,
    input logic                   running,
    input logic                   pre_tc,
    input logic                   end_evt
);
    localparam int RATIO_W = SW_W + MAIN_W;

    logic word_good;
    logic half_route;

    always_comb begin
        word_good  = (ratio_word >= RATIO_W'(MIN_RATIO)) &&
                     (MAIN_W'(ratio_word[SW_W-1:0]) <= ratio_word[RATIO_W-1:SW_W]);
        half_route = (test_sel == 2'b01) && !(refout_en && refout_sel);
    end

    // R4: the divided pulse never lasts two cycles
    assert_fpd_single_R4: assert property (@(posedge clk_rf) disable iff (!rst_n)
        fpd |=> !fpd);

    // R3: modulus only moves at a prescaler boundary
    assert_mod_at_boundary_R3: assert property (@(posedge clk_rf) disable iff (!rst_n)
        (running && !pre_tc) |=> $stable(mod_ctl));

    // R5: illegal word raises the flag
    assert_clamp_flag_R5: assert property (@(posedge clk_rf) disable iff (!rst_n)
        (ratio_load && !word_good) |=> ratio_clamped);

    // R6: legal word clears the flag, no strobe keeps it
    assert_clamp_clear_R6: assert property (@(posedge clk_rf) disable iff (!rst_n)
        (ratio_load && word_good) |=> !ratio_clamped);

    assert_clamp_hold_R6: assert property (@(posedge clk_rf) disable iff (!rst_n)
        !ratio_load |=> $stable(ratio_clamped));

    // R8: Fpd/2 route toggles port 0 at each cycle end
    assert_half_toggle_R8: assert property (@(posedge clk_rf) disable iff (!rst_n)
        (end_evt && half_route) |=> (!half_route || (port0_out != $past(port0_out))));

endmodule

bind swallow_divider swallow_divider_chk #(
    .SW_W(SW_W), .MAIN_W(MAIN_W), .MIN_RATIO(MIN_RATIO)
) u_chk (
    .clk_rf(clk_rf), .rst_n(rst_n), .ratio_word(ratio_word), .ratio_load(ratio_load),
    .test_sel(test_sel), .refout_en(refout_en), .refout_sel(refout_sel),
    .fpd(fpd), .mod_ctl(mod_ctl), .ratio_clamped(ratio_clamped), .port0_out(port0_out),
    .running(running), .pre_tc(pre_tc), .end_evt(end_evt)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk_rf = 1'b0;
    logic        rst_n  = 1'b0;
    logic [14:0] ratio_word = '0;
    logic        ratio_load = 1'b0;
    logic [1:0]  test_sel = 2'b00;
    logic        refout_en = 1'b0;
    logic        refout_sel = 1'b0;
    logic        port0_data = 1'b0;
    logic        fpd, mod_ctl, ratio_clamped, port0_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    swallow_divider dut (
        .clk_rf(clk_rf), .rst_n(rst_n), .ratio_word(ratio_word), .ratio_load(ratio_load),
        .test_sel(test_sel), .refout_en(refout_en), .refout_sel(refout_sel),
        .port0_data(port0_data), .fpd(fpd), .mod_ctl(mod_ctl),
        .ratio_clamped(ratio_clamped), .port0_out(port0_out)
    );

    always #(CLK_PERIOD/2) clk_rf = ~clk_rf;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic load_word(input int w);
        @(negedge clk_rf);
        ratio_word = 15'(w);
        ratio_load = 1'b1;
        @(negedge clk_rf);
        ratio_load = 1'b0;
    endtask

    // from an fpd sample to the next one: period and divide-by-9 cycles
    task automatic measure(output int per, output int hi9);
        while (!fpd) @(negedge clk_rf);
        per = 0;
        hi9 = mod_ctl;
        do begin
            @(negedge clk_rf);
            per++;
            if (!fpd) hi9 += mod_ctl;
        end while (!fpd);
    endtask

    function automatic int eff_ratio(input int w);
        int m = w >> 3;
        int a = w & 7;
        if (w < 56 || a > m) return 56;
        return w;
    endfunction

    task automatic try_ratio(input int w, input string req);
        int per, hi9, e;
        e = eff_ratio(w);
        load_word(w);
        measure(per, hi9);
        measure(per, hi9);
        check(per == 8 * (e >> 3) + (e & 7), req, per, 8 * (e >> 3) + (e & 7));
        check(hi9 == 9 * (e & 7), "R3", hi9, 9 * (e & 7));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk_rf);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int per, hi9, cnt;
        bit p;
        repeat (3) @(negedge clk_rf);
        // R1: reset values
        check(fpd == 0 && mod_ctl == 0, "R1 outputs in reset", {fpd, mod_ctl}, 0);
        check(ratio_clamped == 0, "R1 flag in reset", ratio_clamped, 0);
        rst_n = 1'b1;
        measure(per, hi9);
        measure(per, hi9);
        check(per == 56, "R1 default ratio", per, 56);
        check(ratio_clamped == 0, "R1 flag after reset", ratio_clamped, 0);

        // R2/R3/R4 sweep over every small ratio
        for (int w = 56; w <= 150; w++) try_ratio(w, "R2");

        // R2 random mid-range ratios
        for (int i = 0; i < 5; i++) try_ratio(int'($urandom_range(300, 4000)), "R2 random");

        // R4: pulse width one cycle
        while (!fpd) @(negedge clk_rf);
        @(negedge clk_rf);
        check(fpd == 0, "R4 pulse width", fpd, 0);

        // R7: mid-cycle load keeps current length
        load_word(90);
        measure(per, hi9);
        measure(per, hi9);
        cnt = 0;
        do begin
            @(negedge clk_rf);
            cnt++;
            if (cnt == 20) ratio_word = 15'd77;
            ratio_load = (cnt == 20);
        end while (!fpd);
        check(cnt == 90, "R7 current cycle kept", cnt, 90);
        measure(per, hi9);
        check(per == 77, "R7 new ratio next cycle", per, 77);

        // R5: below-range word and A greater than M
        load_word(10);
        check(ratio_clamped == 1, "R5 flag below range", ratio_clamped, 1);
        measure(per, hi9);
        measure(per, hi9);
        check(per == 56, "R5 clamp below range", per, 56);
        load_word(7);
        check(ratio_clamped == 1, "R5 flag A>M", ratio_clamped, 1);
        measure(per, hi9);
        measure(per, hi9);
        check(per == 56 && hi9 == 0, "R5 clamp A>M", per, 56);

        // R6: legal word clears flag, no strobe holds
        load_word(100);
        check(ratio_clamped == 0, "R6 flag cleared", ratio_clamped, 0);
        measure(per, hi9);
        measure(per, hi9);
        check(per == 100, "R6 ratio after clear", per, 100);
        check(ratio_clamped == 0, "R6 flag held", ratio_clamped, 0);

        // R9: data path
        test_sel = 2'b00; port0_data = 1'b1;
        @(negedge clk_rf);
        check(port0_out == 1, "R9 test 00 data 1", port0_out, 1);
        port0_data = 1'b0;
        @(negedge clk_rf);
        check(port0_out == 0, "R9 test 00 data 0", port0_out, 0);
        test_sel = 2'b01; refout_en = 1'b1; refout_sel = 1'b1; port0_data = 1'b1;
        repeat (120) begin
            @(negedge clk_rf);
            if (port0_out != 1) break;
        end
        check(port0_out == 1, "R9 route blocked by ref bits", port0_out, 1);
        test_sel = 2'b10; refout_en = 1'b0; refout_sel = 1'b0;
        repeat (120) begin
            @(negedge clk_rf);
            if (port0_out != 1) break;
        end
        check(port0_out == 1, "R9 test 10", port0_out, 1);

        // R8: Fpd/2 on port 0
        test_sel = 2'b01; refout_en = 1'b0; refout_sel = 1'b1; port0_data = 1'b0;
        for (int k = 0; k < 3; k++) begin
            do @(negedge clk_rf); while (fpd);
            p = port0_out;
            while (!fpd) @(negedge clk_rf);
            check(port0_out == !p, "R8 toggle at fpd", port0_out, !p);
        end
        test_sel = 2'b00;

        // R10: largest ratio
        load_word(32767);
        measure(per, hi9);
        measure(per, hi9);
        check(per == 32767, "R10 max period", per, 32767);
        check(hi9 == 63, "R3 max swallow cycles", hi9, 63);

        done = 1'b1;
        finish_run();
    end
endmodule